// File: doc/BRIEF.md
# Two-Level WRED Frame Admission

This block rules on every frame that arrives for one of several egress priority queues: it admits the frame, or drops it, before any buffer space is committed. The ruling depends on the target queue's current occupancy, measured against two per-queue thresholds, a lower and an upper one. It also depends on the frame's drop precedence. Frames with high drop precedence are treated harder than frames with low drop precedence. Between the two thresholds, each precedence class sees its own programmable drop percentage. Above the upper threshold, high-precedence frames are always discarded, and low-precedence frames still see a third percentage.

In parallel, the block checks how much buffer the frame's source port is already using against a shared per-port limit. When that limit is exceeded, a mode bit picks the response. One setting raises a pause indication toward the source and admits the frame. The other applies a random drop, using the high-precedence mid-band percentage. Random decisions come from a free-running, seedable 16-bit LFSR, so a known seed makes every decision predictable.

Requests use a valid/ready handshake. The ruling appears on registered outputs one cycle after the request is accepted. Thresholds, percentages, the port limit and the mode bit sit behind a small address/data/write-enable register port, which also reads them back.

Top module: `wred_admit`

## Requirements
- R1: While reset is held, res_valid, res_admit, res_drop, res_pause and req_ready are all low. The registers read back as follows: every lower threshold 0x10, every upper threshold 0x20, percentages X=25, Y=10 and Z=50, source limit 0x12, mode 0.
- R2: Register addresses with the default four queues:
  - 2q holds the lower threshold of queue q, and 2q+1 holds its upper threshold.
  - 8 holds X, 9 holds Y and 10 holds Z. Each keeps wdata[6:0].
  - 11 holds the source limit (8 bits). 12 holds the mode bit, which keeps wdata[0].
  - cfg_rdata shows the register at cfg_addr without a clock, zero-extended, and reflects a write from the cycle after the write edge.
  - Other addresses read 0, and a write to them changes no register.
- R3: req_ready is high from the first clock edge after reset is released. A request accepted at an edge gives res_valid high for exactly the following cycle. A cycle with no accepted request gives res_valid low in the following cycle.
- R4: When res_valid is high, exactly one of res_admit and res_drop is high. When res_valid is low, res_admit, res_drop and res_pause are all low.
- R5: A frame is admitted without pause in both of these cases: its queue occupancy is at most 16 times the queue's lower threshold, and its source port usage is at most 16 times the source limit.
- R6: When occupancy exceeds 16 times the lower threshold but not 16 times the upper threshold, the frame is dropped exactly when rnd < X (high precedence) or rnd < Y (low precedence).
- R7: When occupancy exceeds 16 times the upper threshold, a high-precedence frame is always dropped. A low-precedence frame is dropped exactly when rnd < Z.
- R8: When source usage exceeds 16 times the source limit and mode is 0, res_pause is high with the result. The source check adds no drop of its own in this case.
- R9: When source usage exceeds 16 times the source limit and mode is 1, the source check drops the frame exactly when rnd < X, and res_pause stays low.
- R10: When both checks act on the same frame, the frame is dropped if either one calls for a drop. res_pause still follows R8.
- R11: The LFSR is loaded with the SEED parameter (default 0xACE1) in reset and advances on every clock edge after reset. Each step shifts left, and the new bit 0 is bit15 ^ bit13 ^ bit12 ^ bit10. rnd is bits [6:0] of the state in the cycle the request is accepted, reduced modulo 100.
- R12: Only the thresholds and occupancy of the selected queue, and only the usage of the selected source port, affect a frame's ruling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Frame admission request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_queue | input | QW (2) | Target egress queue |
| req_src | input | SW (3) | Source port of the frame |
| req_hi_drop | input | 1 | 1 = high drop precedence |
| q_occ | input | NQ*OCC_W (48) | Occupancy of each queue in granules, queue q at [q*OCC_W +: OCC_W] |
| src_use | input | NSRC*OCC_W (96) | Buffer usage of each source port in granules |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | AW (4) | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read-back of the addressed register |
| res_valid | output | 1 | Ruling present |
| res_admit | output | 1 | Frame admitted |
| res_drop | output | 1 | Frame dropped |
| res_pause | output | 1 | Pause the source port |

## Verification
The queue-band check and the source-limit check both act on a single frame in a single cycle. The bench provokes this by sweeping queue occupancy across every band edge while the selected source port sits just at, or one granule above, its limit, in both source modes. Each ruling is judged against an arithmetic model that merges the two causes: a drop from either check wins, and pause depends only on the source check. Every other queue and source port is held at full scale, so any cross-selection shows up.

// File: rtl/wred_admit_pkg.sv
package wred_admit_pkg;

    localparam int TH_W    = 8;
    localparam int PCT_W   = 7;
    localparam int RND_W   = 7;
    localparam int LFSR_W  = 16;
    localparam int GRAN_SH = 4;

    localparam logic [TH_W-1:0]  LOW_TH_RST  = 8'h10;
    localparam logic [TH_W-1:0]  HIGH_TH_RST = 8'h20;
    localparam logic [TH_W-1:0]  SRC_LIM_RST = 8'h12;
    localparam logic [PCT_W-1:0] PCT_X_RST   = 7'd25;
    localparam logic [PCT_W-1:0] PCT_Y_RST   = 7'd10;
    localparam logic [PCT_W-1:0] PCT_Z_RST   = 7'd50;

    typedef struct packed {
        logic [PCT_W-1:0] pct_x;
        logic [PCT_W-1:0] pct_y;
        logic [PCT_W-1:0] pct_z;
        logic [TH_W-1:0]  src_lim;
        logic             src_mode;
    } glob_cfg_t;

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/wred_lfsr.sv
module wred_lfsr
    import wred_admit_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [RND_W-1:0] rnd
);
    localparam logic [RND_W-1:0] MOD = RND_W'(100);

    typedef struct packed {
        logic [LFSR_W-1:0] state;
    } lfsr_st_t;

    lfsr_st_t st_d, st_q;
    logic [RND_W-1:0] raw;

    always_comb begin
        st_d       = st_q;
        st_d.state = lfsr_next(st_q.state);
        raw        = st_q.state[RND_W-1:0];
        rnd        = (raw >= MOD) ? raw - MOD : raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: SEED};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wred_cfg_regs.sv
module wred_cfg_regs
    import wred_admit_pkg::*;
#(
    parameter int NQ = 4,
    parameter int AW = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [AW-1:0]             addr,
    input  logic [7:0]                wdata,
    output logic [7:0]                rdata,
    output logic [NQ-1:0][TH_W-1:0]   low_th,
    output logic [NQ-1:0][TH_W-1:0]   high_th,
    output glob_cfg_t                 gcfg
);
    localparam int A_X    = 2 * NQ;
    localparam int A_Y    = 2 * NQ + 1;
    localparam int A_Z    = 2 * NQ + 2;
    localparam int A_LIM  = 2 * NQ + 3;
    localparam int A_MODE = 2 * NQ + 4;

    typedef struct packed {
        logic [NQ-1:0][TH_W-1:0] lo;
        logic [NQ-1:0][TH_W-1:0] hi;
        glob_cfg_t               g;
    } regs_t;

    regs_t st_d, st_q;
    int    a;

    always_comb begin
        st_d  = st_q;
        a     = int'(addr);
        rdata = 8'h00;
        if (we) begin
            for (int i = 0; i < NQ; i++) begin
                if (a == 2 * i)     st_d.lo[i] = wdata;
                if (a == 2 * i + 1) st_d.hi[i] = wdata;
            end
            if (a == A_X)    st_d.g.pct_x    = wdata[PCT_W-1:0];
            if (a == A_Y)    st_d.g.pct_y    = wdata[PCT_W-1:0];
            if (a == A_Z)    st_d.g.pct_z    = wdata[PCT_W-1:0];
            if (a == A_LIM)  st_d.g.src_lim  = wdata;
            if (a == A_MODE) st_d.g.src_mode = wdata[0];
        end
        for (int i = 0; i < NQ; i++) begin
            if (a == 2 * i)     rdata = st_q.lo[i];
            if (a == 2 * i + 1) rdata = st_q.hi[i];
        end
        if (a == A_X)    rdata = {1'b0, st_q.g.pct_x};
        if (a == A_Y)    rdata = {1'b0, st_q.g.pct_y};
        if (a == A_Z)    rdata = {1'b0, st_q.g.pct_z};
        if (a == A_LIM)  rdata = st_q.g.src_lim;
        if (a == A_MODE) rdata = {7'd0, st_q.g.src_mode};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lo         <= {NQ{LOW_TH_RST}};
            st_q.hi         <= {NQ{HIGH_TH_RST}};
            st_q.g.pct_x    <= PCT_X_RST;
            st_q.g.pct_y    <= PCT_Y_RST;
            st_q.g.pct_z    <= PCT_Z_RST;
            st_q.g.src_lim  <= SRC_LIM_RST;
            st_q.g.src_mode <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign low_th  = st_q.lo;
    assign high_th = st_q.hi;
    assign gcfg    = st_q.g;
endmodule

// File: rtl/wred_decide.sv
module wred_decide
    import wred_admit_pkg::*;
#(
    parameter int NQ    = 4,
    parameter int NSRC  = 8,
    parameter int OCC_W = 12,
    parameter int QW    = 2,
    parameter int SW    = 3
) (
    input  logic [QW-1:0]            queue,
    input  logic [SW-1:0]            src,
    input  logic                     hi_drop,
    input  logic [NQ*OCC_W-1:0]      q_occ,
    input  logic [NSRC*OCC_W-1:0]    src_use,
    input  logic [NQ-1:0][TH_W-1:0]  low_th,
    input  logic [NQ-1:0][TH_W-1:0]  high_th,
    input  glob_cfg_t                gcfg,
    input  logic [RND_W-1:0]         rnd,
    output logic                     q_drop,
    output logic                     src_drop,
    output logic                     src_pause
);
    localparam int TH_FULL = TH_W + GRAN_SH;
    localparam int CMP_W   = (OCC_W > TH_FULL) ? OCC_W : TH_FULL;

    logic [NQ-1:0]   over_lo, over_hi;
    logic [NSRC-1:0] over_lim;
    logic [CMP_W-1:0] lim_full;

    assign lim_full = CMP_W'({gcfg.src_lim, {GRAN_SH{1'b0}}});

    for (genvar g = 0; g < NQ; g++) begin : g_queue
        logic [CMP_W-1:0] occ_x, lo_x, hi_x;
        assign occ_x      = CMP_W'(q_occ[g*OCC_W +: OCC_W]);
        assign lo_x       = CMP_W'({low_th[g],  {GRAN_SH{1'b0}}});
        assign hi_x       = CMP_W'({high_th[g], {GRAN_SH{1'b0}}});
        assign over_lo[g] = occ_x > lo_x;
        assign over_hi[g] = occ_x > hi_x;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic [CMP_W-1:0] use_x;
        assign use_x       = CMP_W'(src_use[g*OCC_W +: OCC_W]);
        assign over_lim[g] = use_x > lim_full;
    end

    logic in_hi, in_lo, over_src;
    logic lt_x, lt_y, lt_z;

    always_comb begin
        in_hi    = over_hi[queue];
        in_lo    = over_lo[queue];
        over_src = over_lim[src];
        lt_x     = rnd < gcfg.pct_x;
        lt_y     = rnd < gcfg.pct_y;
        lt_z     = rnd < gcfg.pct_z;
        if (in_hi)      q_drop = hi_drop ? 1'b1 : lt_z;
        else if (in_lo) q_drop = hi_drop ? lt_x : lt_y;
        else            q_drop = 1'b0;
        src_pause = over_src && !gcfg.src_mode;
        src_drop  = over_src &&  gcfg.src_mode && lt_x;
    end
endmodule

// File: rtl/wred_admit.sv
module wred_admit
    import wred_admit_pkg::*;
#(
    parameter int NQ    = 4,
    parameter int NSRC  = 8,
    parameter int OCC_W = 12,
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int AW = $clog2(2 * NQ + 5)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [QW-1:0]          req_queue,
    input  logic [SW-1:0]          req_src,
    input  logic                   req_hi_drop,
    input  logic [NQ*OCC_W-1:0]    q_occ,
    input  logic [NSRC*OCC_W-1:0]  src_use,
    input  logic                   cfg_we,
    input  logic [AW-1:0]          cfg_addr,
    input  logic [7:0]             cfg_wdata,
    output logic [7:0]             cfg_rdata,
    output logic                   res_valid,
    output logic                   res_admit,
    output logic                   res_drop,
    output logic                   res_pause
);
    logic [NQ-1:0][TH_W-1:0] low_th, high_th;
    glob_cfg_t               gcfg;
    logic [RND_W-1:0]        rnd;
    logic                    q_drop, src_drop, src_pause;
    logic                    accept, any_drop;

    wred_cfg_regs #(.NQ(NQ), .AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata),
        .low_th(low_th), .high_th(high_th), .gcfg(gcfg)
    );

    wred_lfsr #(.SEED(SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .rnd(rnd)
    );

    wred_decide #(
        .NQ(NQ), .NSRC(NSRC), .OCC_W(OCC_W), .QW(QW), .SW(SW)
    ) u_decide (
        .queue(req_queue), .src(req_src), .hi_drop(req_hi_drop),
        .q_occ(q_occ), .src_use(src_use),
        .low_th(low_th), .high_th(high_th), .gcfg(gcfg), .rnd(rnd),
        .q_drop(q_drop), .src_drop(src_drop), .src_pause(src_pause)
    );

    typedef struct packed {
        logic ready;
        logic vld;
        logic admit;
        logic drop;
        logic pause;
    } res_st_t;

    res_st_t st_d, st_q;

    always_comb begin
        accept     = req_valid && st_q.ready;
        any_drop   = q_drop || src_drop;
        st_d       = st_q;
        st_d.ready = 1'b1;
        st_d.vld   = accept;
        st_d.admit = accept && !any_drop;
        st_d.drop  = accept &&  any_drop;
        st_d.pause = accept &&  src_pause;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready = st_q.ready;
    assign res_valid = st_q.vld;
    assign res_admit = st_q.admit;
    assign res_drop  = st_q.drop;
    assign res_pause = st_q.pause;
endmodule

// File: rtl/wred_admit_chk.sv
module wred_admit_chk
    import wred_admit_pkg::*;
#(
    parameter int NQ    = 4,
    parameter int OCC_W = 12,
    parameter int QW    = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic [QW-1:0]           req_queue,
    input logic                    req_hi_drop,
    input logic [NQ*OCC_W-1:0]     q_occ,
    input logic [NQ-1:0][TH_W-1:0] high_th,
    input logic                    src_mode,
    input logic                    res_valid,
    input logic                    res_admit,
    input logic                    res_drop,
    input logic                    res_pause
);
    logic [NQ-1:0] full_q;
    logic          sel_full;

    always_comb begin
        for (int i = 0; i < NQ; i++)
            full_q[i] = int'(q_occ[i*OCC_W +: OCC_W]) > int'(high_th[i]) * 16;
        sel_full = full_q[req_queue];
    end

    AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> res_valid); // R3
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !res_valid); // R3
    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> req_ready); // R3
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $onehot({res_admit, res_drop})); // R4
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(res_admit || res_drop || res_pause)); // R4
    AST_HI_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_hi_drop && sel_full) |=> res_drop); // R7
    AST_PAUSE_MODE0: assert property (@(posedge clk) disable iff (!rst_n)
        res_pause |-> !$past(src_mode)); // R9
endmodule

bind wred_admit wred_admit_chk #(.NQ(NQ), .OCC_W(OCC_W), .QW(QW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_queue(req_queue), .req_hi_drop(req_hi_drop), .q_occ(q_occ),
    .high_th(high_th), .src_mode(gcfg.src_mode),
    .res_valid(res_valid), .res_admit(res_admit), .res_drop(res_drop),
    .res_pause(res_pause)
);

// File: tb/wred_admit_bench.sv
module wred_admit_bench;
    localparam int NQ = 4, NSRC = 8, OCC_W = 12;
    localparam logic [15:0] SEED = 16'hACE1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready, req_hi_drop = 1'b0;
    logic [1:0] req_queue = '0;
    logic [2:0] req_src = '0;
    logic [NQ*OCC_W-1:0]   q_occ = '0;
    logic [NSRC*OCC_W-1:0] src_use = '0;
    logic cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0, cfg_rdata;
    logic res_valid, res_admit, res_drop, res_pause;

    wred_admit #(.NQ(NQ), .NSRC(NSRC), .OCC_W(OCC_W), .SEED(SEED)) u_wred_admit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_queue(req_queue), .req_src(req_src), .req_hi_drop(req_hi_drop),
        .q_occ(q_occ), .src_use(src_use), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .res_valid(res_valid),
        .res_admit(res_admit), .res_drop(res_drop), .res_pause(res_pause)
    );

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0, fails = 0;
    bit done = 1'b0;
    int sh_lo[NQ], sh_hi[NQ];
    int sh_x = 25, sh_y = 10, sh_z = 50, sh_lim = 18, sh_mode = 0;

    // R11 model of the random source
    logic [15:0] m_lfsr;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_lfsr <= SEED;
        else        m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input string tag, input int a, input int exp);
        cfg_addr = 4'(a);
        #1;
        chk(tag, int'(cfg_rdata), exp);
    endtask

    task automatic rd_all(input string tag);
        for (int q = 0; q < NQ; q++) begin
            rd(tag, 2 * q, sh_lo[q]);
            rd(tag, 2 * q + 1, sh_hi[q]);
        end
        rd(tag, 8, sh_x); rd(tag, 9, sh_y); rd(tag, 10, sh_z);
        rd(tag, 11, sh_lim); rd(tag, 12, sh_mode);
    endtask

    task automatic do_req(input int q, input int s, input int hi, input int occ, input int use_v);
        int r, th1, th2, lim, qd, so, pz, dr;
        string tag;
        @(negedge clk);
        for (int i = 0; i < NQ; i++)   q_occ[i*OCC_W +: OCC_W]   = (i == q) ? OCC_W'(occ)   : '1;
        for (int i = 0; i < NSRC; i++) src_use[i*OCC_W +: OCC_W] = (i == s) ? OCC_W'(use_v) : '1;
        req_queue = 2'(q); req_src = 3'(s); req_hi_drop = hi[0]; req_valid = 1'b1;
        r   = int'(m_lfsr[6:0]); if (r >= 100) r -= 100;
        th1 = sh_lo[q] * 16; th2 = sh_hi[q] * 16; lim = sh_lim * 16;
        if (occ > th2)      qd = hi ? 1 : int'(r < sh_z);
        else if (occ > th1) qd = hi ? int'(r < sh_x) : int'(r < sh_y);
        else                qd = 0;
        so = int'(use_v > lim);
        pz = so & int'(sh_mode == 0);
        dr = qd | (so & sh_mode & int'(r < sh_x));
        if (qd && so)      tag = "R10";
        else if (so)       tag = sh_mode ? "R9" : "R8";
        else if (occ > th2) tag = "R7";
        else if (occ > th1) tag = "R6";
        else               tag = "R5";
        tag = {tag, " (R11,R12,R4)"};
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, int'({res_valid, res_admit, res_drop, res_pause}),
            int'({1'b1, dr == 0, dr == 1, pz == 1}));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int occs[5];
        for (int q = 0; q < NQ; q++) begin sh_lo[q] = 16; sh_hi[q] = 32; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 res_valid", int'(res_valid), 0);
        chk("R1 outputs", int'({res_admit, res_drop, res_pause}), 0);
        chk("R1 ready", int'(req_ready), 0);
        rd_all("R1 readback");
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R3 ready", int'(req_ready), 1);
        chk("R3 idle", int'(res_valid), 0);

        // R2: register map, field widths, unmapped address
        wr(8, 8'hFF); sh_x = 8'h7F; rd("R2 X width", 8, sh_x);
        wr(12, 8'hFE); rd("R2 mode bit0", 12, 0);
        wr(13, 8'hFF); rd("R2 unmapped", 13, 0);
        rd_all("R2 unchanged");
        for (int q = 0; q < NQ; q++) begin
            sh_lo[q] = 2 + q; sh_hi[q] = 5 + 2 * q;
            wr(2 * q, sh_lo[q]); wr(2 * q + 1, sh_hi[q]);
        end
        sh_x = 25; wr(8, sh_x);
        rd_all("R2 programmed");

        // R5..R12 sweep
        for (int pc = 0; pc < 2; pc++) begin
            if (pc == 0) begin sh_x = 25; sh_y = 10; sh_z = 50; end
            else         begin sh_x = 100; sh_y = 0; sh_z = 100; end
            wr(8, sh_x); wr(9, sh_y); wr(10, sh_z);
            for (int md = 0; md < 2; md++) begin
                sh_mode = md; wr(12, md);
                for (int q = 0; q < NQ; q++) begin
                    occs[0] = 0; occs[1] = sh_lo[q] * 16; occs[2] = sh_lo[q] * 16 + 1;
                    occs[3] = sh_hi[q] * 16; occs[4] = sh_hi[q] * 16 + 1;
                    for (int oi = 0; oi < 5; oi++)
                        for (int hi = 0; hi < 2; hi++)
                            for (int ui = 0; ui < 2; ui++)
                                do_req(q, (q * 2 + oi) % NSRC, hi, occs[oi], sh_lim * 16 + ui);
                end
            end
        end
        @(negedge clk);
        chk("R3 no request", int'(res_valid), 0);
        chk("R4 idle outputs", int'({res_admit, res_drop, res_pause}), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule